// File: doc/BRIEF.md
# Multi-channel framed link with CRC-12 check

This block is the link layer of a network interface on an on-chip network. On the transmit side it takes a 32-bit payload word and computes a 12-bit CRC over it. It then sends payload and CRC as a single frame, one slice per handshake. Each slice is carried across a parameterised group of narrow channels. Every channel is `CH_W` bits wide (1 to 4), and there are `CH_N` channels (typically 6, 8 or 16). A destination field, fixed by configuration, travels beside each frame so that the network can route it statically.

The receive side collects the slices of a frame and recomputes the CRC. It then presents the payload together with a one-cycle valid pulse and an error flag. The check only detects errors. A mismatch sends nothing back: there is no negative acknowledge and no resend. The host sees the error through the flag and through a saturating 8-bit error counter that it can read and clear. Recovery is left to software.

Top module: `nlink_top`

## Requirements
- R1: A frame is the 32-bit payload followed by its 12-bit CRC. Zero bits are appended at the least significant end until the frame fills NSLICE = ceil(44 / (CH_N*CH_W)) slices. Slices are sent most significant first: `link_data` bit SLICE_W-1 carries the earliest frame bit of the slice. With the defaults there are 3 slices of 16 bits and 4 pad bits.
- R2: The CRC uses generator x^12+x^11+x^3+x^2+x+1. Its initial value is zero, and it is computed over the payload starting with bit 31.
- R3: While `link_valid` is high and `link_ready` is low, `link_data` and `link_valid` hold their values. The transmitter moves to the next slice only on a cycle where both are high.
- R4: A payload is taken only when `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after acceptance until the last slice has been handed over. A payload offered during that time has no effect on the frame in flight.
- R5: `frame_valid` is high for exactly one cycle, in the cycle after the last slice of a frame is accepted on the receive side. In that cycle `frame_payload` shows the received payload, which then stays until the next frame completes. `rx_ready` is always high.
- R6: `crc_error` is high only in a `frame_valid` cycle. It is high exactly when the CRC recomputed over the received payload differs from the received CRC field.
- R7: A receive error produces no transmit activity: `link_valid` stays low unless a new payload is accepted.
- R8: Each frame with a CRC error increments `err_count` by one in the same cycle that `frame_valid` rises. The count saturates at 255.
- R9: `err_clear` sets `err_count` to zero on the next edge. This takes priority over an increment in the same cycle.
- R10: `link_dest` shows the value of `cfg_dest` sampled when the payload was accepted. It stays stable for the whole frame, whatever `cfg_dest` does meanwhile.
- R11: After reset `in_ready` is 1, and `link_valid`, `frame_valid`, `crc_error` and `err_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dest | input | DEST_W | Configured destination field |
| in_valid | input | 1 | Payload offered to transmitter |
| in_ready | output | 1 | Transmitter can take a payload |
| in_payload | input | 32 | Payload word to send |
| link_valid | output | 1 | Outgoing slice valid |
| link_ready | input | 1 | Network takes outgoing slice |
| link_data | output | CH_N*CH_W | Outgoing slice, all channels |
| link_dest | output | DEST_W | Destination of frame in flight |
| rx_valid | input | 1 | Incoming slice valid |
| rx_ready | output | 1 | Receiver takes incoming slice |
| rx_data | input | CH_N*CH_W | Incoming slice, all channels |
| frame_valid | output | 1 | One-cycle pulse, received frame done |
| frame_payload | output | 32 | Received payload |
| crc_error | output | 1 | CRC mismatch, with frame_valid |
| err_clear | input | 1 | Host clear of error counter |
| err_count | output | 8 | Saturating receive error count |

## Verification
The bench targets four kinds of case. Stalls on `link_ready` in the middle of a frame check that the transmitter does not skip or repeat a slice, which would show up as a wrong slice value. Payloads such as all-ones and single-bit patterns expose a wrong generator, a wrong bit order or a wrong pad placement, because each of these gives a different CRC field. Corrupting the CRC field and corrupting a payload bit check the error flag; a design that compared the wrong fields would flag good frames or miss bad ones. Pushing more than 255 error frames, and clearing in the same cycle as an error, checks that the counter neither wraps to zero nor lets the increment beat the clear.

// File: rtl/nlink_pkg.sv
package nlink_pkg;
  localparam int PAY_W = 32;
  localparam int CRC_W = 12;
  localparam int FRAME_W = PAY_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 12'h80F;

  // bitwise CRC, zero start, payload MSB first
  function automatic logic [CRC_W-1:0] crc12(input logic [PAY_W-1:0] data);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data[i];
      c = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/nlink_tx.sv
module nlink_tx
  import nlink_pkg::*;
#(
  parameter int SLICE_W = 16,
  parameter int NSLICE  = 3,
  parameter int DEST_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEST_W-1:0]  cfg_dest,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PAY_W-1:0]   in_payload,
  output logic               link_valid,
  input  logic               link_ready,
  output logic [SLICE_W-1:0] link_data,
  output logic [DEST_W-1:0]  link_dest,
  output logic               accept_evt,
  output logic               beat_evt
);
  localparam int PADW     = NSLICE * SLICE_W;
  localparam int PAD_BITS = PADW - FRAME_W;
  localparam int CNT_W    = $clog2(NSLICE + 1);

  logic [PADW-1:0]   shreg;
  logic [CNT_W-1:0]  cnt;
  logic              busy;
  logic [DEST_W-1:0] dest_q;

  assign in_ready   = !busy;
  assign accept_evt = in_valid && !busy;
  assign beat_evt   = busy && link_ready;
  assign link_valid = busy;
  assign link_data  = shreg[PADW-1 -: SLICE_W];
  assign link_dest  = dest_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      dest_q <= '0;
    end else if (accept_evt) begin
      shreg  <= PADW'({in_payload, crc12(in_payload)}) << PAD_BITS;
      cnt    <= '0;
      busy   <= 1'b1;
      dest_q <= cfg_dest;
    end else if (beat_evt) begin
      shreg <= shreg << SLICE_W;
      if (cnt == CNT_W'(NSLICE - 1)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nlink_rx.sv
module nlink_rx
  import nlink_pkg::*;
#(
  parameter int SLICE_W = 16,
  parameter int NSLICE  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [SLICE_W-1:0] rx_data,
  output logic               frame_valid,
  output logic [PAY_W-1:0]   frame_payload,
  output logic               crc_error,
  output logic               frame_done,
  output logic               crc_mis_evt
);
  localparam int PADW  = NSLICE * SLICE_W;
  localparam int CNT_W = $clog2(NSLICE + 1);

  logic [PADW-1:0]  acc;
  logic [PADW-1:0]  acc_next;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] got_pay;
  logic [CRC_W-1:0] got_crc;

  assign rx_ready    = 1'b1;
  assign acc_next    = (acc << SLICE_W) | PADW'(rx_data);
  assign got_pay     = acc_next[PADW-1 -: PAY_W];
  assign got_crc     = acc_next[PADW-PAY_W-1 -: CRC_W];
  assign frame_done  = rx_valid && (cnt == CNT_W'(NSLICE - 1));
  assign crc_mis_evt = frame_done && (crc12(got_pay) != got_crc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc           <= '0;
      cnt           <= '0;
      frame_valid   <= 1'b0;
      crc_error     <= 1'b0;
      frame_payload <= '0;
    end else begin
      frame_valid <= frame_done;
      crc_error   <= crc_mis_evt;
      if (frame_done) begin
        frame_payload <= got_pay;
        acc           <= '0;
        cnt           <= '0;
      end else if (rx_valid) begin
        acc <= acc_next;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nlink_errcnt.sv
module nlink_errcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/nlink_top.sv
module nlink_top
  import nlink_pkg::*;
#(
  parameter int CH_N   = 8,
  parameter int CH_W   = 2,
  parameter int DEST_W = 4,
  parameter int ERR_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DEST_W-1:0]    cfg_dest,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_payload,
  output logic                 link_valid,
  input  logic                 link_ready,
  output logic [CH_N*CH_W-1:0] link_data,
  output logic [DEST_W-1:0]    link_dest,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  input  logic [CH_N*CH_W-1:0] rx_data,
  output logic                 frame_valid,
  output logic [31:0]          frame_payload,
  output logic                 crc_error,
  input  logic                 err_clear,
  output logic [ERR_W-1:0]     err_count
);
  localparam int SLICE_W = CH_N * CH_W;
  localparam int NSLICE  = (FRAME_W + SLICE_W - 1) / SLICE_W;

  logic tx_accept_evt;
  logic tx_beat_evt;
  logic rx_frame_done;
  logic rx_crc_mis;

  nlink_tx #(.SLICE_W(SLICE_W), .NSLICE(NSLICE), .DEST_W(DEST_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_dest   (cfg_dest),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_payload (in_payload),
    .link_valid (link_valid),
    .link_ready (link_ready),
    .link_data  (link_data),
    .link_dest  (link_dest),
    .accept_evt (tx_accept_evt),
    .beat_evt   (tx_beat_evt)
  );

  nlink_rx #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .rx_data       (rx_data),
    .frame_valid   (frame_valid),
    .frame_payload (frame_payload),
    .crc_error     (crc_error),
    .frame_done    (rx_frame_done),
    .crc_mis_evt   (rx_crc_mis)
  );

  nlink_errcnt #(.CW(ERR_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (rx_crc_mis),
    .clr   (err_clear),
    .count (err_count)
  );
endmodule

// File: rtl/nlink_chk.sv
module nlink_chk #(
  parameter int SW = 16,
  parameter int DW = 4,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          link_valid,
  input logic          link_ready,
  input logic [SW-1:0] link_data,
  input logic [DW-1:0] link_dest,
  input logic          frame_done,
  input logic          frame_valid,
  input logic          crc_error,
  input logic          err_clear,
  input logic [EW-1:0] err_count
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && !link_ready) |=> (link_valid && $stable(link_data)));
  // R4
  busy_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> !in_ready);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> frame_valid);
  // R6
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |-> frame_valid);
  // R7
  no_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_valid && !(in_valid && in_ready)) |=> !link_valid);
  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == {EW{1'b1}} && !err_clear) |=> (err_count == {EW{1'b1}}));
  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> (err_count == '0));
  // R10
  dest_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && !link_ready) |=> $stable(link_dest));
endmodule

bind nlink_top nlink_chk #(.SW(SLICE_W), .DW(DEST_W), .EW(ERR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .link_valid  (link_valid),
  .link_ready  (link_ready),
  .link_data   (link_data),
  .link_dest   (link_dest),
  .frame_done  (rx_frame_done),
  .frame_valid (frame_valid),
  .crc_error   (crc_error),
  .err_clear   (err_clear),
  .err_count   (err_count)
);

// File: tb/sim_nlink_top.sv
module sim_nlink_top;
  localparam int SW = 16;
  localparam int NS = 3;
  localparam int PADW = SW * NS;
  localparam int PADB = PADW - 44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_dest = '0;
  logic in_valid = 1'b0;
  logic [31:0] in_payload = '0;
  logic link_ready = 1'b0;
  logic rx_valid = 1'b0;
  logic [SW-1:0] rx_data = '0;
  logic err_clear = 1'b0;
  logic in_ready, link_valid, rx_ready, frame_valid, crc_error;
  logic [SW-1:0] link_data;
  logic [3:0] link_dest;
  logic [31:0] frame_payload;
  logic [7:0] err_count;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  nlink_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dest(cfg_dest), .in_valid(in_valid),
    .in_ready(in_ready), .in_payload(in_payload), .link_valid(link_valid),
    .link_ready(link_ready), .link_data(link_data), .link_dest(link_dest),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .frame_valid(frame_valid), .frame_payload(frame_payload),
    .crc_error(crc_error), .err_clear(err_clear), .err_count(err_count)
  );

  // polynomial long division, generator 0x180F
  function automatic logic [11:0] ref_crc(input logic [31:0] p);
    logic [43:0] r;
    r = {p, 12'h000};
    for (int i = 43; i >= 12; i--)
      if (r[i]) r[i -: 13] = r[i -: 13] ^ 13'h180F;
    return r[11:0];
  endfunction

  function automatic logic [PADW-1:0] build(input logic [31:0] p, input logic [11:0] c);
    logic [PADW-1:0] f;
    f = PADW'({p, c});
    return f << PADB;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model of the receive side and error counter
  logic [SW-1:0] q[$];
  logic exp_fv = 1'b0, exp_err = 1'b0;
  logic [31:0] exp_pay = '0;
  int exp_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_fv <= 1'b0; exp_err <= 1'b0; exp_cnt <= 0; exp_pay <= '0;
    end else begin
      logic fv_n, er_n;
      int cnt_n;
      fv_n = 1'b0; er_n = 1'b0; cnt_n = exp_cnt;
      if (rx_valid) begin
        q.push_back(rx_data);
        if (q.size() == NS) begin
          logic [PADW-1:0] f;
          f = '0;
          foreach (q[i]) f = (f << SW) | PADW'(q[i]);
          q.delete();
          fv_n = 1'b1;
          exp_pay <= f[PADW-1 -: 32];
          er_n = (ref_crc(f[PADW-1 -: 32]) != f[PADW-33 -: 12]);
          if (er_n && cnt_n < 255) cnt_n = cnt_n + 1;
        end
      end
      if (err_clear) cnt_n = 0;
      exp_fv <= fv_n; exp_err <= er_n; exp_cnt <= cnt_n;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(frame_valid == exp_fv, "R5", "frame_valid", 64'(frame_valid), 64'(exp_fv));
      check(crc_error == exp_err, "R6", "crc_error", 64'(crc_error), 64'(exp_err));
      check(int'(err_count) == exp_cnt, "R8", "err_count", 64'(err_count), 64'(exp_cnt));
      check(rx_ready == 1'b1, "R5", "rx_ready", 64'(rx_ready), 64'd1);
      if (exp_fv)
        check(frame_payload == exp_pay, "R1", "frame_payload", 64'(frame_payload), 64'(exp_pay));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // drive one received frame; crc_flip / pay_flip corrupt it
  task automatic rx_frame(input logic [31:0] p, input logic [11:0] crc_flip,
                          input logic [31:0] pay_flip, input int gap, input bit clr_last);
    logic [PADW-1:0] f;
    f = build(p ^ pay_flip, ref_crc(p) ^ crc_flip);
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data = f[PADW-1-k*SW -: SW];
      err_clear = clr_last && (k == NS - 1);
      for (int g = 0; g < gap && k < NS - 1; g++) begin
        @(negedge clk);
        rx_valid = 1'b0;
        rx_data = '1;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0;
    err_clear = 1'b0;
  endtask

  // send one payload and collect its slices with given stall count
  task automatic tx_frame(input logic [31:0] p, input logic [3:0] d, input int stall);
    logic [PADW-1:0] f;
    f = build(p, ref_crc(p));
    @(negedge clk);
    check(in_ready == 1'b1, "R4", "in_ready idle", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_payload = p; cfg_dest = d; link_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; cfg_dest = ~d;
    for (int k = 0; k < NS; k++) begin
      for (int s = 0; s < stall; s++) begin
        link_ready = 1'b0;
        in_valid = (s == 0); in_payload = ~p;
        check(link_data == f[PADW-1-k*SW -: SW], "R3", "stalled slice",
              64'(link_data), 64'(f[PADW-1-k*SW -: SW]));
        check(link_valid == 1'b1, "R3", "valid in stall", 64'(link_valid), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
      end
      check(link_valid == 1'b1, "R1", "slice valid", 64'(link_valid), 64'd1);
      check(link_data == f[PADW-1-k*SW -: SW], "R2", "slice data",
            64'(link_data), 64'(f[PADW-1-k*SW -: SW]));
      check(link_dest == d, "R10", "link_dest", 64'(link_dest), 64'(d));
      check(in_ready == 1'b0, "R4", "in_ready busy", 64'(in_ready), 64'd0);
      link_ready = 1'b1;
      @(negedge clk);
    end
    link_ready = 1'b0;
    check(link_valid == 1'b0, "R4", "valid after frame", 64'(link_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R11", "in_ready", 64'(in_ready), 64'd1);
    check(link_valid == 1'b0, "R11", "link_valid", 64'(link_valid), 64'd0);
    check(frame_valid == 1'b0, "R11", "frame_valid", 64'(frame_valid), 64'd0);
    check(crc_error == 1'b0, "R11", "crc_error", 64'(crc_error), 64'd0);
    check(err_count == 8'd0, "R11", "err_count", 64'(err_count), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    model_on = 1'b1;

    // transmit: R1 R2 R3 R4 R10
    tx_frame(32'h0000_0000, 4'h3, 0);
    tx_frame(32'hFFFF_FFFF, 4'hA, 2);
    tx_frame(32'h8000_0001, 4'h5, 1);
    tx_frame(32'hA5C3_1E7F, 4'hF, 3);

    // receive good frames, with and without gaps: R5 R6
    rx_frame(32'h1234_5678, 12'h0, 32'h0, 0, 1'b0);
    rx_frame(32'hFFFF_FFFF, 12'h0, 32'h0, 2, 1'b0);
    rx_frame(32'h0000_0001, 12'h0, 32'h0, 1, 1'b0);
    // corrupted crc and payload: R6 R8
    rx_frame(32'hDEAD_BEEF, 12'h001, 32'h0, 0, 1'b0);
    rx_frame(32'hCAFE_F00D, 12'h0, 32'h0001_0000, 0, 1'b0);
    // R7: no transmit activity after receive error
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(link_valid == 1'b0, "R7", "no resend", 64'(link_valid), 64'd0);
    end
    // R9 clear alone, then clear beside an error
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
    check(err_count == 8'd0, "R9", "cleared", 64'(err_count), 64'd0);
    rx_frame(32'h0F0F_0F0F, 12'h800, 32'h0, 0, 1'b0);
    rx_frame(32'h0F0F_0F0F, 12'h800, 32'h0, 0, 1'b1);
    @(negedge clk);
    check(err_count == 8'd0, "R9", "clear beats increment", 64'(err_count), 64'd0);
    // R8 saturation
    for (int i = 0; i < 260; i++)
      rx_frame(32'(i * 7919), 12'h0A5, 32'h0, 0, 1'b0);
    @(negedge clk);
    check(err_count == 8'd255, "R8", "saturated", 64'(err_count), 64'd255);
    rx_frame(32'h5555_AAAA, 12'h0, 32'h0, 0, 1'b0);
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule